// File: doc/BRIEF.md
# Pulse-Position Response Transmitter

This block drives the data line of an inductively coupled transponder when the tag answers a reader. It sends a 16-bit or 32-bit answer word as a train of pulse-position symbols. It also sends two fixed pulse patterns: one confirms a completed write, the other confirms that a serial number matched. The block controls only the timing of the line clamp. The logic that decides when to answer and what to answer with sits outside it, and so do the clamp transistors.

All timing is counted in time elements (TE). An external `te_tick` strobe, one clock wide, marks the start of each TE. A request is a `start` strobe together with a request kind and, for data requests, a word and a length select. The block latches the request and raises `busy`. From the next tick onward it moves through one TE slot per tick. When the last slot has run out it drops `busy` and pulses `done`. A data answer always opens with a fixed two-symbol preamble. The acknowledge patterns are separate sequences and carry no preamble.

Top module: `ppm_resp_tx`

## Requirements
- R1: While reset is held, and right after it is released, `clamp`, `busy` and `done` are all 0.
- R2: A `start` that is accepted raises `busy` in the clock cycle after the strobe. `busy` then stays high until the pattern has finished.
- R3: `clamp` changes only on the clock edge that samples `te_tick` high. The first TE slot of a pattern appears on the first tick after the accepting edge, and each later tick moves the output forward by exactly one slot.
- R4: Every data answer starts with two preamble symbols: a 0 symbol, then a 1 symbol.
- R5: A 0 symbol is one active slot (`clamp`=1) followed by one idle slot. A 1 symbol is two active slots followed by one idle slot.
- R6: `kind`=00 asks for a data answer. With `len_long`=1 all 32 bits of `word` are sent. With `len_long`=0 only `word[15:0]` is sent. In both cases the bits go out most significant first.
- R7: `kind`=01 asks for a write acknowledge. It is four slots: active, idle, active, idle.
- R8: `kind`=10 asks for a match acknowledge. It is 20 slots: four one-TE pulses spaced one TE apart, a three-slot gap, two such pulses, another three-slot gap, two more pulses, and one final idle slot. Written as slot levels this is 1010101 000 101 000 101 0.
- R9: The tick that comes after the last slot drives `clamp` to 0 and drops `busy`. On that same edge `done` goes high for exactly one cycle.
- R10: A `start` that arrives while `busy` is high is ignored. The pattern in progress goes on unchanged.
- R11: A `start` with `kind`=11 is ignored, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle |
| kind | input | 2 | Request kind: 00 data, 01 write ack, 10 match ack, 11 none |
| len_long | input | 1 | Data length select: 1 = 32 bits, 0 = 16 bits |
| word | input | DATA_W | Answer word, latched on an accepted start |
| te_tick | input | 1 | One-cycle strobe at each TE boundary |
| clamp | output | 1 | Line clamp drive, 1 = active |
| busy | output | 1 | High while a request is being sent |
| done | output | 1 | One-cycle pulse when a request finishes |

## Verification
The bench builds every slot sequence it expects from the requirements and compares each one against the output, slot by slot. All-ones and all-zeros words stress the symbol length. A design that shortened the 1 symbol, or dropped the idle slot, would put every later slot out of step. A 16-bit request is sent with non-zero upper bits in the word. A design that chose the wrong half, or sent the least significant bit first, would show a wrong level within the first few data slots. Strobes that arrive during a transfer, and strobes with the unused kind, are checked through `busy` and through the slots that follow. A design that restarted on such a strobe would break the stream in progress or raise `busy` when it should not. The end of each pattern is checked through `done` and the idle line, which catches off-by-one errors on the last slot.

// File: rtl/ppm_tx_pkg.sv
package ppm_tx_pkg;

  typedef enum logic [1:0] {
    REQ_DATA = 2'b00,
    REQ_WACK = 2'b01,
    REQ_MACK = 2'b10,
    REQ_NONE = 2'b11
  } req_kind_e;

  localparam int WACK_SLOTS = 4;
  localparam int MACK_SLOTS = 20;
  localparam int ACK_IDX_W  = 5;

  // Number of active slots that open a symbol carrying bit b.
  function automatic logic [1:0] sym_high_slots(input logic b);
    return b ? 2'd2 : 2'd1;
  endfunction

  // Active level of slot idx inside a symbol.
  function automatic logic sym_level(input logic b, input logic [1:0] idx);
    return idx < sym_high_slots(b);
  endfunction

  // True on the trailing idle slot of a symbol.
  function automatic logic sym_is_last(input logic b, input logic [1:0] idx);
    return idx == sym_high_slots(b);
  endfunction

  // Write acknowledge: even slots active, odd slots idle.
  function automatic logic wack_level(input logic [ACK_IDX_W-1:0] idx);
    return (int'(idx) < WACK_SLOTS) && !idx[0];
  endfunction

  // Match acknowledge: pulse groups of 4, 2 and 2, each followed by a
  // three-slot gap, except the last which is followed by one idle slot.
  function automatic logic mack_level(input logic [ACK_IDX_W-1:0] idx);
    logic [MACK_SLOTS-1:0] pat;
    pat = 20'b1010101_000_101_000_101_0;
    if (int'(idx) >= MACK_SLOTS) return 1'b0;
    return pat[MACK_SLOTS-1-int'(idx)];
  endfunction

endpackage

// File: rtl/ppm_bit_shifter.sv
module ppm_bit_shifter
  import ppm_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              len_long,
  input  logic [DATA_W-1:0] word,
  input  logic              adv,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam int SH_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LONG_LEFT  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] SHORT_LEFT = CNT_W'(SHORT_W + 1);

  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      if (len_long) begin
        shreg <= {2'b01, word};
        left  <= LONG_LEFT;
      end else begin
        shreg <= {2'b01, word[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};
        left  <= SHORT_LEFT;
      end
    end else if (adv) begin
      shreg <= {shreg[SH_W-2:0], 1'b0};
      if (left != '0) left <= left - 1'b1;
    end
  end

  assign cur_bit  = shreg[SH_W-1];
  assign last_bit = (left == '0);

  AST_LEFT_DROPS_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && left != '0) |=> (left == $past(left) - 1'b1)); // R6

endmodule

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer
  import ppm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       adv,
  input  logic       bit_val,
  output logic       level,
  output logic       sym_last
);
  logic [1:0] slot_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)            slot_idx <= '0;
    else if (clear)        slot_idx <= '0;
    else if (adv) begin
      if (sym_last)        slot_idx <= '0;
      else                 slot_idx <= slot_idx + 1'b1;
    end
  end

  assign level    = sym_level(bit_val, slot_idx);
  assign sym_last = sym_is_last(bit_val, slot_idx);

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= 2'd2); // R5

endmodule

// File: rtl/ppm_ack_pattern.sv
module ppm_ack_pattern
  import ppm_tx_pkg::*;
(
  input  logic [1:0]           kind,
  input  logic [ACK_IDX_W-1:0] idx,
  output logic                 level,
  output logic                 last
);
  always_comb begin
    level = 1'b0;
    last  = 1'b0;
    case (kind)
      REQ_WACK: begin
        level = wack_level(idx);
        last  = int'(idx) == WACK_SLOTS - 1;
      end
      REQ_MACK: begin
        level = mack_level(idx);
        last  = int'(idx) == MACK_SLOTS - 1;
      end
      default: begin
        level = 1'b0;
        last  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ppm_resp_tx.sv
module ppm_resp_tx
  import ppm_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic              len_long,
  input  logic [DATA_W-1:0] word,
  input  logic              te_tick,
  output logic              clamp,
  output logic              busy,
  output logic              done
);
  logic       busy_q, fin_q, clamp_q, done_q;
  logic [1:0] kind_q;
  logic [ACK_IDX_W-1:0] ack_idx;

  // Named events
  logic accept, step, finish, is_data;
  logic cur_bit, last_bit, sym_lvl, sym_last;
  logic ack_lvl, ack_last;
  logic cur_level, cur_last;

  assign accept  = start && !busy_q && (kind != REQ_NONE);
  assign step    = busy_q && te_tick && !fin_q;
  assign finish  = busy_q && te_tick && fin_q;
  assign is_data = (kind_q == REQ_DATA);

  ppm_bit_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .len_long (len_long),
    .word     (word),
    .adv      (step && is_data && sym_last),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  ppm_slot_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .adv      (step && is_data),
    .bit_val  (cur_bit),
    .level    (sym_lvl),
    .sym_last (sym_last)
  );

  ppm_ack_pattern u_ack (
    .kind  (kind_q),
    .idx   (ack_idx),
    .level (ack_lvl),
    .last  (ack_last)
  );

  assign cur_level = is_data ? sym_lvl : ack_lvl;
  assign cur_last  = is_data ? (sym_last && last_bit) : ack_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      clamp_q <= 1'b0;
      done_q  <= 1'b0;
      kind_q  <= REQ_DATA;
      ack_idx <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        fin_q   <= 1'b0;
        clamp_q <= 1'b0;
        kind_q  <= kind;
        ack_idx <= '0;
      end else if (step) begin
        clamp_q <= cur_level;
        fin_q   <= cur_last;
        ack_idx <= ack_idx + 1'b1;
      end else if (finish) begin
        busy_q  <= 1'b0;
        fin_q   <= 1'b0;
        clamp_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  assign clamp = clamp_q;
  assign busy  = busy_q;
  assign done  = done_q;

  AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !clamp_q); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))); // R9
  AST_CLAMP_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_q != $past(clamp_q)) |-> $past(te_tick)); // R3
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> busy_q); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q); // R2
  AST_NONE_KIND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && kind == REQ_NONE) |=> !busy_q); // R11

endmodule

// File: tb/test_ppm_resp_tx.sv
module test_ppm_resp_tx;
  localparam int DATA_W = 32;

  typedef struct {
    int    lvl;   // 0/1 slot level, 2 = end of pattern
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] kind = 2'b00;
  logic len_long = 1'b0;
  logic [DATA_W-1:0] word = '0;
  logic te_tick = 1'b0;
  logic clamp, busy, done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit ticking = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  ppm_resp_tx #(.DATA_W(DATA_W), .SHORT_W(16)) i_ppm_resp_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .len_long(len_long), .word(word), .te_tick(te_tick),
    .clamp(clamp), .busy(busy), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Ticker and monitor: tick is driven at negedges where cyc%4==0 and
  // consumed by the following edge; results are read where cyc%4==1.
  always @(negedge clk) begin
    te_tick <= ticking && (cyc % 4 == 0);
    if (ticking && (cyc % 4 == 1) && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.lvl == 2) begin
        check(!busy, {e.tag, " busy at end"}, busy, 0);
        check(!clamp, {e.tag, " clamp at end"}, clamp, 0);
        check(done, {e.tag, " done pulse"}, done, 1);
      end else begin
        check(busy, {e.tag, " busy during slot"}, busy, 1);
        check(clamp == e.lvl[0], {e.tag, " slot level"}, clamp, e.lvl);
      end
    end
  end

  task automatic push(input int lvl, input string tag);
    exp_t e;
    e.lvl = lvl;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_symbol(input bit b, input string tag);
    push(1, tag);
    if (b) push(1, tag);
    push(0, tag);
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while (cyc % 4 != ph);
  endtask

  // Driver: issues a request and pushes the expected slots.
  task automatic send(input logic [1:0] k, input bit lng, input logic [DATA_W-1:0] w,
                      input string tag);
    wait_phase(2);
    kind = k; len_long = lng; word = w; start = 1'b1;
    if (k == 2'b00) begin
      int n;
      n = lng ? 32 : 16;
      push_symbol(1'b0, {tag, " preamble R4"});
      push_symbol(1'b1, {tag, " preamble R4"});
      for (int i = n - 1; i >= 0; i--) push_symbol(w[i], {tag, " data R5 R6"});
    end else if (k == 2'b01) begin
      for (int i = 0; i < 2; i++) begin push(1, {tag, " R7"}); push(0, {tag, " R7"}); end
    end else begin
      int grp[3] = '{4, 2, 2};
      for (int g = 0; g < 3; g++) begin
        for (int p = 0; p < grp[g]; p++) begin
          push(1, {tag, " R8"});
          if (p != grp[g] - 1) push(0, {tag, " R8"});
        end
        if (g != 2) for (int z = 0; z < 3; z++) push(0, {tag, " R8"});
        else push(0, {tag, " R8"});
      end
    end
    push(2, {tag, " R9"});
    @(negedge clk);
    start = 1'b0;
    check(busy, {tag, " R2 busy after start"}, busy, 1);
    check(!clamp, {tag, " R3 no slot before first tick"}, clamp, 0);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!clamp && !busy && !done, "R1 reset outputs", {clamp, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!clamp && !busy && !done, "R1 after reset", {clamp, busy, done}, 0);
    ticking = 1'b1;

    send(2'b00, 1'b0, 32'hFFFF_1234, "short word");
    drain();

    send(2'b00, 1'b1, 32'hA5C3_0F81, "long word");
    repeat (20) @(negedge clk);
    wait_phase(2);
    kind = 2'b01; word = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10 busy kept on start while busy", busy, 1);
    drain();

    send(2'b00, 1'b1, 32'hFFFF_FFFF, "all ones");
    drain();
    send(2'b00, 1'b0, 32'h0000_0000, "all zeros");
    drain();
    send(2'b01, 1'b0, 32'h0, "write ack");
    drain();
    send(2'b10, 1'b0, 32'h0, "match ack");
    drain();

    wait_phase(2);
    kind = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R11 unused kind ignored", busy, 0);
    repeat (8) @(negedge clk);
    check(!busy && !clamp, "R11 line stays idle", {busy, clamp}, 0);

    send(2'b00, 1'b0, 32'h0000_8001, "edge bits");
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule